// File: doc/BRIEF.md
# Access Indicator and Reset Pulser

This block sits behind the bus decoder of a carrier board that hosts five plug-in module slots. Every select strobe that the decoder raises for a slot, and the strobe it raises for the carrier's own registers, is stretched into a pulse long enough to see on a front-panel lamp. That gives six indicators in all. Each indicator is retriggerable, so a burst of accesses keeps its lamp lit without a break.

The block also drives the five module reset lines. Software writes a mask into a reset command. Every bit written as 1 starts a reset one-shot for that slot, and the one-shot holds the slot in reset for a minimum width. The system reset is ORed onto every module reset line. A status vector lets software poll each slot until its reset has been released. Hold lengths are parameters. The defaults assume a 50 MHz clock: about 20 ms for an indicator and 200 ms for a reset.

Top module: `access_pulse_ctrl`

## Requirements
- R1: While `rst` is high and on the first cycle after it, every indicator is off, and each bit of `mod_rst_o` and `rst_status_o` equals `sys_rst`.
- R2: When `slot_sel[i]` is sampled high at a clock edge, `led_o[i]` is high for exactly `LED_HOLD` cycles starting at that edge, provided there is no further trigger.
- R3: A select sampled while an indicator is lit reloads its full `LED_HOLD` count from that edge.
- R4: `led_o[NSLOT]` (bit 5 by default) is the carrier-register indicator and follows `creg_sel` with the same timing as R2 and R3.
- R5: A write with `rst_wr_en` high and `rst_wr_data[i]` = 1 drives `mod_rst_o[i]` high for exactly `RST_HOLD` cycles starting at that edge.
- R6: A bit of `rst_wr_data` written as 0 has no effect. An idle slot stays out of reset, and a running reset pulse keeps its remaining length.
- R7: `mod_rst_o[i]` is the OR of `sys_rst` and slot i's one-shot. `sys_rst` forces every module reset high in the same cycle without disturbing the one-shots.
- R8: `rst_status_o[i]` is 1 exactly when `mod_rst_o[i]` is 1, on every cycle.
- R9: Writing all ones starts the reset pulse of all five slots together.
- R10: Writing 1 to a slot whose reset is still active restarts its full `RST_HOLD` width from the new write.
- R11: `rst_wr_data` is ignored while `rst_wr_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset of the pulse counters |
| sys_rst | input | 1 | System reset level merged onto every module reset |
| slot_sel | input | NSLOT | Per-slot access select strobes from the decoder |
| creg_sel | input | 1 | Carrier-register access select strobe |
| rst_wr_en | input | 1 | Reset command write strobe |
| rst_wr_data | input | NSLOT | Reset command mask, 1 = start that slot's reset |
| led_o | output | NSLOT+1 | Indicators: bits 0..NSLOT-1 for the slots, bit NSLOT for the carrier registers |
| mod_rst_o | output | NSLOT | Module reset outputs, active high |
| rst_status_o | output | NSLOT | Software view of each slot's reset activity |

## Verification
Several properties are checked on every cycle. A trigger always lights its pulse on the next cycle, and a count of one with no trigger always ends it. Counters never exceed their hold value. `sys_rst` always forces every module reset. The status view always agrees with the reset outputs. Zero bits and unenabled writes never start a reset. The exact pulse lengths, the restart of a hold by a retrigger, the all-slot reset and the way `sys_rst` overlaps a running pulse can only be shown by the bench's scenarios, which compare against a counting model.

// File: rtl/apc_pkg.sv
package apc_pkg;

    localparam int SLOTS_DEF = 5;

    // Which kind of pulse a bank produces
    typedef enum logic [0:0] {
        PK_INDICATOR = 1'b0,
        PK_RESET     = 1'b1
    } pulse_kind_e;

    // Counter width able to hold the value 'hold'
    function automatic int cnt_width(input int hold);
        int w;
        w = $clog2(hold + 1);
        return (w < 1) ? 1 : w;
    endfunction

endpackage

// File: rtl/apc_oneshot.sv
module apc_oneshot #(
    parameter int                  HOLD = 4,
    parameter apc_pkg::pulse_kind_e KIND = apc_pkg::PK_INDICATOR
) (
    input  logic clk,
    input  logic rst,
    input  logic trig,
    output logic pulse_o,
    output logic busy_o
);
    localparam int CW = apc_pkg::cnt_width(HOLD);

    logic [CW-1:0] cnt_q;
    logic          act_q;

    // Retriggerable: every trigger reloads the full hold
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            act_q <= 1'b0;
        end else if (trig) begin
            cnt_q <= CW'(HOLD);
            act_q <= 1'b1;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CW'(1);
            act_q <= (cnt_q != CW'(1));
        end
    end

    assign pulse_o = act_q;
    assign busy_o  = (cnt_q != '0);

    AST_TRIG_ARMS: assert property (@(posedge clk) disable iff (rst)
        trig |=> pulse_o); // R2

    AST_HOLD_EXPIRES: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == CW'(1) && !trig) |=> !pulse_o); // R5

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CW'(HOLD)); // R3

    if (KIND == apc_pkg::PK_RESET) begin : g_rst_kind
        AST_RST_MIN_WIDTH: assert property (@(posedge clk) disable iff (rst)
            (pulse_o && !trig && cnt_q > CW'(1)) |=> pulse_o); // R10
    end
endmodule

// File: rtl/apc_led_bank.sv
module apc_led_bank #(
    parameter int NSLOT    = 5,
    parameter int LED_HOLD = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NSLOT-1:0] slot_sel,
    input  logic             creg_sel,
    output logic [NSLOT:0]   led_o
);
    localparam int NLED = NSLOT + 1;

    logic [NLED-1:0] trig_w;
    logic [NLED-1:0] pulse_w;
    logic [NLED-1:0] busy_w;

    // Top bit is the carrier-register indicator
    assign trig_w = {creg_sel, slot_sel};

    for (genvar i = 0; i < NLED; i++) begin : g_led
        apc_oneshot #(
            .HOLD (LED_HOLD),
            .KIND (apc_pkg::PK_INDICATOR)
        ) u_os (
            .clk     (clk),
            .rst     (rst),
            .trig    (trig_w[i]),
            .pulse_o (pulse_w[i]),
            .busy_o  (busy_w[i])
        );

        AST_LED_COHERENT: assert property (@(posedge clk) disable iff (rst)
            pulse_w[i] == busy_w[i]); // R4
    end

    // Lamps follow the one-shots combinationally
    assign led_o = pulse_w;
endmodule

// File: rtl/apc_rst_bank.sv
module apc_rst_bank #(
    parameter int NSLOT    = 5,
    parameter int RST_HOLD = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sys_rst,
    input  logic             wr_en,
    input  logic [NSLOT-1:0] wr_data,
    output logic [NSLOT-1:0] mod_rst_o,
    output logic [NSLOT-1:0] status_o
);
    logic [NSLOT-1:0] trig_w;
    logic [NSLOT-1:0] pulse_w;
    logic [NSLOT-1:0] busy_w;

    // Only bits written as 1 under the strobe start a pulse
    assign trig_w = {NSLOT{wr_en}} & wr_data;

    for (genvar i = 0; i < NSLOT; i++) begin : g_slot
        apc_oneshot #(
            .HOLD (RST_HOLD),
            .KIND (apc_pkg::PK_RESET)
        ) u_os (
            .clk     (clk),
            .rst     (rst),
            .trig    (trig_w[i]),
            .pulse_o (pulse_w[i]),
            .busy_o  (busy_w[i])
        );

        AST_ZERO_BIT_INERT: assert property (@(posedge clk) disable iff (rst)
            (wr_en && !wr_data[i] && !pulse_w[i]) |=> !pulse_w[i]); // R6

        AST_WRITE_GATED: assert property (@(posedge clk) disable iff (rst)
            (!wr_en && !pulse_w[i]) |=> !pulse_w[i]); // R11
    end

    // Output path uses the pulse flag, status uses the counter
    assign mod_rst_o = {NSLOT{sys_rst}} | pulse_w;
    assign status_o  = {NSLOT{sys_rst}} | busy_w;
endmodule

// File: rtl/access_pulse_ctrl.sv
module access_pulse_ctrl #(
    parameter int NSLOT    = apc_pkg::SLOTS_DEF,
    parameter int LED_HOLD = 1_000_000,
    parameter int RST_HOLD = 10_000_000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sys_rst,
    input  logic [NSLOT-1:0] slot_sel,
    input  logic             creg_sel,
    input  logic             rst_wr_en,
    input  logic [NSLOT-1:0] rst_wr_data,
    output logic [NSLOT:0]   led_o,
    output logic [NSLOT-1:0] mod_rst_o,
    output logic [NSLOT-1:0] rst_status_o
);
    apc_led_bank #(
        .NSLOT    (NSLOT),
        .LED_HOLD (LED_HOLD)
    ) u_led (
        .clk      (clk),
        .rst      (rst),
        .slot_sel (slot_sel),
        .creg_sel (creg_sel),
        .led_o    (led_o)
    );

    apc_rst_bank #(
        .NSLOT    (NSLOT),
        .RST_HOLD (RST_HOLD)
    ) u_rst (
        .clk       (clk),
        .rst       (rst),
        .sys_rst   (sys_rst),
        .wr_en     (rst_wr_en),
        .wr_data   (rst_wr_data),
        .mod_rst_o (mod_rst_o),
        .status_o  (rst_status_o)
    );

    AST_SYS_FORCES_ALL: assert property (@(posedge clk) disable iff (rst)
        sys_rst |-> (&mod_rst_o)); // R7

    AST_STATUS_MATCH: assert property (@(posedge clk) disable iff (rst)
        rst_status_o == mod_rst_o); // R8

    AST_ALL_SLOTS_START: assert property (@(posedge clk) disable iff (rst)
        (rst_wr_en && (&rst_wr_data)) |=> (&mod_rst_o)); // R9
endmodule

// File: tb/sim_access_pulse_ctrl.sv
module sim_access_pulse_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NS  = 5;
    localparam int LH  = 6;
    localparam int RH  = 10;
    localparam int WATCHDOG = 5000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          sys_rst = 1'b0;
    logic [NS-1:0] slot_sel = '0;
    logic          creg_sel = 1'b0;
    logic          wr_en = 1'b0;
    logic [NS-1:0] wr_data = '0;
    logic [NS:0]   led_o;
    logic [NS-1:0] mod_rst_o;
    logic [NS-1:0] rst_status_o;

    int n_chk  = 0;
    int n_fail = 0;
    int cycles = 0;
    string cur_req = "R1";

    // Behavioural model: remaining cycles per pulse
    int led_left [NS+1];
    int rst_left [NS];

    always #(CLK_PERIOD/2) clk = ~clk;

    access_pulse_ctrl #(.NSLOT(NS), .LED_HOLD(LH), .RST_HOLD(RH)) u0 (
        .clk(clk), .rst(rst), .sys_rst(sys_rst), .slot_sel(slot_sel),
        .creg_sel(creg_sel), .rst_wr_en(wr_en), .rst_wr_data(wr_data),
        .led_o(led_o), .mod_rst_o(mod_rst_o), .rst_status_o(rst_status_o)
    );

    initial begin
        for (int i = 0; i <= NS; i++) led_left[i] = 0;
        for (int i = 0; i < NS; i++) rst_left[i] = 0;
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        for (int i = 0; i <= NS; i++) begin
            if (rst) led_left[i] = 0;
            else if ((i < NS) ? slot_sel[i] : creg_sel) led_left[i] = LH;
            else if (led_left[i] > 0) led_left[i] = led_left[i] - 1;
        end
        for (int i = 0; i < NS; i++) begin
            if (rst) rst_left[i] = 0;
            else if (wr_en && wr_data[i]) rst_left[i] = RH;
            else if (rst_left[i] > 0) rst_left[i] = rst_left[i] - 1;
        end
    end

    task automatic compare();
        logic [NS:0]   exp_led;
        logic [NS-1:0] exp_rst;
        for (int i = 0; i <= NS; i++) exp_led[i] = (led_left[i] > 0);
        for (int i = 0; i < NS; i++) exp_rst[i] = sys_rst | (rst_left[i] > 0);
        n_chk++;
        if (led_o !== exp_led) begin
            n_fail++;
            $display("FAIL %s led_o actual=%b expected=%b", cur_req, led_o, exp_led);
        end
        n_chk++;
        if (mod_rst_o !== exp_rst) begin
            n_fail++;
            $display("FAIL %s mod_rst_o actual=%b expected=%b", cur_req, mod_rst_o, exp_rst);
        end
        n_chk++; // R8 status view
        if (rst_status_o !== exp_rst) begin
            n_fail++;
            $display("FAIL R8 rst_status_o actual=%b expected=%b", rst_status_o, exp_rst);
        end
    endtask

    task automatic cyc(input logic r, input logic [NS-1:0] s, input logic c,
                       input logic we, input logic [NS-1:0] wd, input logic sr);
        @(negedge clk);
        compare();
        rst = r; slot_sel = s; creg_sel = c; wr_en = we; wr_data = wd; sys_rst = sr;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) cyc(1'b0, '0, 1'b0, 1'b0, '0, 1'b0);
    endtask

    initial begin
        // R1: reset state, also with sys_rst raised
        cur_req = "R1";
        cyc(1'b1, '0, 1'b0, 1'b0, '0, 1'b0);
        cyc(1'b1, 5'b10101, 1'b1, 1'b1, 5'b11111, 1'b1);
        cyc(1'b1, '0, 1'b0, 1'b0, '0, 1'b0);
        idle(2);
        // R2: single slot access stretched
        cur_req = "R2";
        cyc(1'b0, 5'b00010, 1'b0, 1'b0, '0, 1'b0);
        idle(LH + 3);
        // R3: retrigger while lit
        cur_req = "R3";
        cyc(1'b0, 5'b01000, 1'b0, 1'b0, '0, 1'b0);
        idle(3);
        cyc(1'b0, 5'b01000, 1'b0, 1'b0, '0, 1'b0);
        idle(LH + 3);
        // R4: carrier register indicator
        cur_req = "R4";
        cyc(1'b0, '0, 1'b1, 1'b0, '0, 1'b0);
        cyc(1'b0, 5'b00001, 1'b1, 1'b0, '0, 1'b0);
        idle(LH + 2);
        // R5: single slot reset pulse
        cur_req = "R5";
        cyc(1'b0, '0, 1'b0, 1'b1, 5'b00100, 1'b0);
        idle(RH + 3);
        // R6: zero bits leave running and idle slots alone
        cur_req = "R6";
        cyc(1'b0, '0, 1'b0, 1'b1, 5'b00010, 1'b0);
        idle(3);
        cyc(1'b0, '0, 1'b0, 1'b1, 5'b00000, 1'b0);
        idle(RH + 2);
        // R10: rewrite restarts the width
        cur_req = "R10";
        cyc(1'b0, '0, 1'b0, 1'b1, 5'b00001, 1'b0);
        idle(5);
        cyc(1'b0, '0, 1'b0, 1'b1, 5'b00001, 1'b0);
        idle(RH + 3);
        // R9: all slots together
        cur_req = "R9";
        cyc(1'b0, '0, 1'b0, 1'b1, 5'b11111, 1'b0);
        idle(RH + 3);
        // R11: data without the write strobe
        cur_req = "R11";
        for (int k = 0; k < 3; k++) cyc(1'b0, '0, 1'b0, 1'b0, 5'b11111, 1'b0);
        idle(3);
        // R7: system reset overlapping a running pulse
        cur_req = "R7";
        cyc(1'b0, '0, 1'b0, 1'b1, 5'b00100, 1'b0);
        idle(2);
        for (int k = 0; k < 3; k++) cyc(1'b0, '0, 1'b0, 1'b0, '0, 1'b1);
        idle(RH + 2);
        for (int k = 0; k < 2; k++) cyc(1'b0, '0, 1'b0, 1'b0, '0, 1'b1);
        idle(2);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        wait (cycles >= WATCHDOG);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog %s actual=%0d cycles expected<%0d", cur_req, cycles, WATCHDOG);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule